// File: doc/BRIEF.md
# Root Hub Downstream Port Status and Control Register

This block holds the status and control state of one downstream port of a USB host root hub, as host software sees it through a simple register read/write port. It tracks whether a device is attached, whether the port is enabled, whether a port reset is running, and whether the port is powered. Software acts on it only by writing ones. Each command position sets or clears one piece of state. Writing zero anywhere does nothing.

A port reset is timed inside the block. It lasts a fixed, parameterised number of clock cycles. When it ends, the reset status bit clears by itself, the port becomes enabled and a reset-change flag is raised. Software polls the reset status bit to learn when the reset is over. Three change flags record events the hardware saw: an attach or detach, a loss of enable caused by a detach, and a completed reset. Software clears each flag by writing 1 to its position.

A second, hub-level register holds a global power switch. The port counts as powered only when its own power switch and the global switch are both on.

Top module: `rh_port_status`

## Requirements
- R1: After reset, both registers read 0 when no device is attached, and the outputs `port_enabled`, `port_in_reset` and `port_powered` are 0.
- R2: Port bit 0 shows `dev_present` one clock edge later. Any change of that bit sets the connect-change flag at port bit 16. Writing 1 to bit 16 clears the flag.
- R3: Writing 1 to port bit 4 starts a reset. Bit 4, and `port_in_reset` with it, then reads 1 for exactly RST_CYCLES clock cycles after the write edge, and then clears without any software action.
- R4: When a reset ends normally, the port enable (port bit 1) is set and the reset-change flag at port bit 20 is set. Writing 1 to bit 20 clears that flag.
- R5: Writing 1 to port bit 1 enables the port, but only when the port is powered and a device is attached. Writing 1 to port bit 0 disables the port and raises no change flag.
- R6: A write of 0 to either register changes no state.
- R7: A device detach clears the port enable. If the port was enabled, the detach also sets the enable-change flag at port bit 17, which writing 1 clears. A detach during a reset ends the reset at once, and the reset-change flag is not raised.
- R8: A reset request is ignored while the port is unpowered or no device is attached.
- R9: Writing 1 to port bit 8 turns on the port power switch, which reads back at bit 8. Writing 1 to port bit 9 turns it off. In the hub register, writing 1 to bit 16 turns global power on, writing 1 to bit 0 turns it off, and bit 0 reads the global power state. When the port loses power, its enable is cleared and any running reset is ended, and no change flag is raised.
- R10: When hardware sets a change flag in the same cycle that software writes 1 to clear it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 = port register, 1 = hub register |
| wr_en | input | 1 | Write strobe for the selected register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected register (combinational) |
| dev_present | input | 1 | Device-attach level from the line-state logic |
| port_enabled | output | 1 | Port enable state |
| port_in_reset | output | 1 | High while a port reset is being driven |
| port_powered | output | 1 | Port power switch and global power switch both on |

## Verification
On any of the three change flags, a hardware set can land in the same cycle as a software write-one-to-clear of that flag. The bench provokes this twice. First, it drops `dev_present` on the same edge as a write that clears the connect-change flag. Second, it times a clear of the reset-change flag so that it lands exactly on the edge where the reset timer expires. In both cases the flag must read 1 afterwards, and a later plain clear must return it to 0.

// File: rtl/rh_pkg.sv
`timescale 1ns/1ps
package rh_pkg;
  // Port register bit positions (software decodes these)
  localparam int P_CONN   = 0;   // read: connect status, write 1: disable port
  localparam int P_EN     = 1;   // read: enable, write 1: enable port
  localparam int P_RST    = 4;   // read: reset running, write 1: start reset
  localparam int P_PWR    = 8;   // read: power switch, write 1: power on
  localparam int P_PWROFF = 9;   // write 1: power off
  localparam int P_CSC    = 16;  // connect change flag
  localparam int P_ENC    = 17;  // enable change flag
  localparam int P_RSTC   = 20;  // reset change flag
  // Hub register bit positions
  localparam int H_GOFF   = 0;   // read: global power, write 1: global off
  localparam int H_GON    = 16;  // write 1: global on

  localparam int NCHG = 3;
  localparam int CHG_POS [NCHG] = '{P_CSC, P_ENC, P_RSTC};

  // Last counted cycle of a reset of length len
  function automatic logic rst_last(input logic [31:0] cnt, input logic [31:0] len);
    return cnt == len - 32'd1;
  endfunction

  // Assemble the port register read image
  function automatic logic [31:0] pack_port(input logic conn, input logic en,
                                            input logic rst, input logic pwr,
                                            input logic [NCHG-1:0] chg);
    logic [31:0] v;
    v = '0;
    v[P_CONN] = conn;
    v[P_EN]   = en;
    v[P_RST]  = rst;
    v[P_PWR]  = pwr;
    for (int i = 0; i < NCHG; i++) v[CHG_POS[i]] = chg[i];
    return v;
  endfunction
endpackage

// File: rtl/rh_chg_bit.sv
`timescale 1ns/1ps
module rh_chg_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  // R10: a hardware set is never lost to a same-cycle clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  // R10: a clear alone empties the flag
  a_r10_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/rh_rst_timer.sv
`timescale 1ns/1ps
module rh_rst_timer #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  output logic active_o,
  output logic done_o
);
  import rh_pkg::*;
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = rst_last(32'(cnt_q), 32'(LEN));
  assign done_o = active_o && last && !abort_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (abort_i) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i && !active_o) begin
      active_o <= 1'b1;
      cnt_q    <= '0;
    end else if (active_o) begin
      if (last) begin
        active_o <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3: the count never passes the programmed length
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (cnt_q <= CW'(LEN - 1)));
  // R3: completion ends the reset on the next edge
  a_r3_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !active_o);
endmodule

// File: rtl/rh_port_status.sv
`timescale 1ns/1ps
module rh_port_status #(
  parameter int RST_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        dev_present,
  output logic        port_enabled,
  output logic        port_in_reset,
  output logic        port_powered
);
  import rh_pkg::*;

  logic conn_q, en_q, ppwr_q, gpwr_q;
  logic ppwr_d, gpwr_d;
  logic wp, wh;
  logic conn_fall, conn_edge;
  logic powered, pwr_drop;
  logic rst_start, rst_abort, rst_done, rst_active;
  logic en_clr, en_set;
  logic [NCHG-1:0] chg_set, chg_clr, chg_q;
  logic unused_wbits;

  assign unused_wbits = ^wdata;

  assign wp = wr_en && !reg_sel;
  assign wh = wr_en &&  reg_sel;

  // Connect tracking
  assign conn_fall = conn_q && !dev_present;
  assign conn_edge = conn_q != dev_present;

  // Power switches: the on-command has priority over the off-command
  always_comb begin
    ppwr_d = ppwr_q;
    if (wp && wdata[P_PWR])         ppwr_d = 1'b1;
    else if (wp && wdata[P_PWROFF]) ppwr_d = 1'b0;
    gpwr_d = gpwr_q;
    if (wh && wdata[H_GON])         gpwr_d = 1'b1;
    else if (wh && wdata[H_GOFF])   gpwr_d = 1'b0;
  end

  assign powered  = ppwr_q && gpwr_q;
  assign pwr_drop = powered && !(ppwr_d && gpwr_d);

  // Reset control
  assign rst_start = wp && wdata[P_RST] && powered && conn_q && !rst_active;
  assign rst_abort = conn_fall || pwr_drop;

  rh_rst_timer #(.LEN(RST_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (rst_start),
    .abort_i  (rst_abort),
    .active_o (rst_active),
    .done_o   (rst_done)
  );

  // Enable control
  assign en_clr = conn_fall || pwr_drop || (wp && wdata[P_CONN]);
  assign en_set = rst_done || (wp && wdata[P_EN] && powered && conn_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      en_q   <= 1'b0;
      ppwr_q <= 1'b0;
      gpwr_q <= 1'b0;
    end else begin
      conn_q <= dev_present;
      ppwr_q <= ppwr_d;
      gpwr_q <= gpwr_d;
      if (en_clr)      en_q <= 1'b0;
      else if (en_set) en_q <= 1'b1;
    end
  end

  // Change flags: 0 connect, 1 enable, 2 reset
  assign chg_set[0] = conn_edge;
  assign chg_set[1] = en_q && conn_fall;
  assign chg_set[2] = rst_done;

  for (genvar gi = 0; gi < NCHG; gi++) begin : g_chg
    assign chg_clr[gi] = wp && wdata[CHG_POS[gi]];
    rh_chg_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (chg_set[gi]),
      .clr_i (chg_clr[gi]),
      .q_o   (chg_q[gi])
    );
  end

  assign rdata = reg_sel ? {31'b0, gpwr_q}
                         : pack_port(conn_q, en_q, rst_active, ppwr_q, chg_q);

  assign port_enabled  = en_q;
  assign port_in_reset = rst_active;
  assign port_powered  = powered;

  // R2: connect status follows the input one edge later
  a_r2_conn_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    conn_edge |=> (conn_q == $past(dev_present)) && chg_q[0]);
  // R4: normal reset completion enables the port and flags it
  a_r4_done_enables: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |=> en_q && chg_q[2]);
  // R7: detach removes the enable and stops any reset
  a_r7_detach_clears: assert property (@(posedge clk) disable iff (!rst_n)
    conn_fall |=> !en_q && !rst_active);
  // R8: a reset only starts on a powered, attached port
  a_r8_start_guard: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_active) |-> $past(powered) && $past(conn_q));
  // R6: with no write and no line event the enable holds
  a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !conn_edge && !rst_active) |=> $stable(en_q) && $stable(ppwr_q) && $stable(gpwr_q));
  // R9: losing power leaves the port disabled and out of reset
  a_r9_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_drop |=> !en_q && !rst_active && !port_powered);
endmodule

// File: tb/rh_port_status_tb.sv
`timescale 1ns/1ps
module rh_port_status_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        dev_present = 1'b0;
  logic        port_enabled, port_in_reset, port_powered;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  rh_port_status #(.RST_CYCLES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .dev_present(dev_present), .port_enabled(port_enabled),
    .port_in_reset(port_in_reset), .port_powered(port_powered)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    reg_sel = sel;
    #1;
    d = rdata;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    rd(0, v); chk("R1 port reg", v, 32'h0);
    rd(1, v); chk("R1 hub reg", v, 32'h0);
    chk("R1 outputs", {29'b0, port_enabled, port_in_reset, port_powered}, 32'h0);
  endtask

  task automatic t_connect();
    logic [31:0] v;
    @(negedge clk); dev_present = 1'b1;
    @(negedge clk);
    rd(0, v); chk("R2 attach sets status and flag", v, 32'h0001_0001);
    wr(0, 32'h0001_0000);
    rd(0, v); chk("R2 flag cleared", v, 32'h0000_0001);
  endtask

  task automatic t_unpowered();
    logic [31:0] v;
    wr(0, 32'h10);
    rd(0, v); chk("R8 reset ignored unpowered", v, 32'h1);
    chk("R8 no reset drive", {31'b0, port_in_reset}, 32'h0);
    wr(0, 32'h2);
    rd(0, v); chk("R5 enable needs power", v, 32'h1);
  endtask

  task automatic t_power();
    logic [31:0] v;
    wr(1, 32'h0001_0000);
    rd(1, v); chk("R9 global on", v, 32'h1);
    wr(0, 32'h100);
    rd(0, v); chk("R9 port power on", v, 32'h101);
    chk("R9 powered out", {31'b0, port_powered}, 32'h1);
  endtask

  task automatic t_zero_write();
    logic [31:0] v;
    wr(0, 32'h0); wr(1, 32'h0);
    rd(0, v); chk("R6 zero write port", v, 32'h101);
    rd(1, v); chk("R6 zero write hub", v, 32'h1);
  endtask

  task automatic t_port_reset();
    logic [31:0] v;
    wr(0, 32'h10);
    rd(0, v); chk("R3 reset running", v, 32'h111);
    repeat (N - 1) @(negedge clk);
    chk("R3 still in reset at last cycle", {31'b0, port_in_reset}, 32'h1);
    @(negedge clk);
    rd(0, v); chk("R4 reset end enables and flags", v, 32'h0010_0103);
    wr(0, 32'h0010_0000);
    rd(0, v); chk("R4 reset flag cleared", v, 32'h103);
  endtask

  task automatic t_enable_cmds();
    logic [31:0] v;
    wr(0, 32'h1);
    rd(0, v); chk("R5 disable without flag", v, 32'h101);
    wr(0, 32'h2);
    rd(0, v); chk("R5 enable command", v, 32'h103);
  endtask

  task automatic t_collide_rstc();
    logic [31:0] v;
    wr(0, 32'h10);
    repeat (N - 2) @(negedge clk);
    wr(0, 32'h0010_0000);  // lands on the expiry edge
    rd(0, v); chk("R10 reset flag set beats clear", v, 32'h0010_0103);
    wr(0, 32'h0010_0000);
    rd(0, v); chk("R10 reset flag later clear", v, 32'h103);
  endtask

  task automatic t_disconnect();
    logic [31:0] v;
    @(negedge clk); dev_present = 1'b0;
    @(negedge clk);
    rd(0, v); chk("R7 detach", v, 32'h0003_0100);
    chk("R7 enable out", {31'b0, port_enabled}, 32'h0);
    wr(0, 32'h0003_0000);
    rd(0, v); chk("R7 flags cleared", v, 32'h100);
    // detach during a reset
    @(negedge clk); dev_present = 1'b1;
    wr(0, 32'h0001_0000);
    wr(0, 32'h10);
    repeat (3) @(negedge clk);
    dev_present = 1'b0;
    @(negedge clk);
    chk("R7 detach aborts reset", {31'b0, port_in_reset}, 32'h0);
    repeat (N) @(negedge clk);
    rd(0, v); chk("R7 aborted reset no flag", v, 32'h0001_0100);
    wr(0, 32'h0001_0000);
  endtask

  task automatic t_collide_csc();
    logic [31:0] v;
    @(negedge clk); dev_present = 1'b1;
    @(negedge clk);
    rd(0, v); chk("R2 reattach", v, 32'h0001_0101);
    dev_present = 1'b0; reg_sel = 1'b0; wr_en = 1'b1; wdata = 32'h0001_0000;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    rd(0, v); chk("R10 connect flag set beats clear", v, 32'h0001_0100);
    wr(0, 32'h0001_0000);
    rd(0, v); chk("R10 connect flag later clear", v, 32'h100);
  endtask

  task automatic t_power_loss();
    logic [31:0] v;
    @(negedge clk); dev_present = 1'b1;
    wr(0, 32'h0001_0000);
    wr(0, 32'h2);
    rd(0, v); chk("R5 re-enable", v, 32'h103);
    wr(1, 32'h1);
    rd(1, v); chk("R9 global off", v, 32'h0);
    rd(0, v); chk("R9 power loss drops enable", v, 32'h101);
    chk("R9 powered out low", {30'b0, port_powered, port_enabled}, 32'h0);
    wr(0, 32'h10);
    rd(0, v); chk("R8 reset ignored global off", v, 32'h101);
    wr(1, 32'h0001_0000);
    wr(0, 32'h200);
    rd(0, v); chk("R9 port power off", v, 32'h1);
    chk("R9 powered out after port off", {31'b0, port_powered}, 32'h0);
    @(negedge clk); dev_present = 1'b0;
    @(negedge clk);
    wr(0, 32'h10);
    rd(0, v); chk("R8 reset ignored no device", v, 32'h0001_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_connect();
    t_unpowered();
    t_power();
    t_zero_write();
    t_port_reset();
    t_enable_cmds();
    t_collide_rstc();
    t_disconnect();
    t_collide_csc();
    t_power_loss();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule